// File: doc/BRIEF.md
# Multi-Plane Raster Logic Unit

The block applies one logic operation to the same byte address in up to four bit planes of video memory. Software first loads a small register file: an operation word, a per-plane colour byte, a pixel write mask, a plane-skip byte and one tile byte per plane. A single-cycle start pulse with a byte address then launches the job. The block reads the byte from each enabled plane and combines it with the operation's new value. It writes the result back into the same plane, and only then moves on to the next plane.

Each plane computes its new value from its own colour bit. A mask bit of 1 keeps the old pixel. When compare gating is enabled, an externally supplied compare-status byte also decides, pixel by pixel, whether the new value or the old one is written. Some planes are excluded from the job: planes beyond the active plane count, planes with their skip bit set, and the lowest three planes when the external multi-page mask marks them. These planes are not accessed at all.

Top module: `raster_logic_unit`

## Requirements
- R1: After reset every register reads back 0 through `reg_rdata` (address 0 operation, 1 colour, 2 mask, 3 plane skip, 4+p tile of plane p), `busy` is low and `mem_req` is low.
- R2: When bit 7 of the operation word is 0, a start pulse causes no memory access and `busy` stays low.
- R3: Planes are visited in ascending order. Each plane gets one read cycle (`mem_req`=1, `mem_we`=0), immediately followed by one write cycle to the same plane, both at the start address. `busy` is high for exactly two cycles per visited plane, beginning the cycle after start.
- R4: Only planes below min(`plane_count`, 4) are accessed; values above 4 act as 4.
- R5: A plane whose skip bit (bit p of register 3) is 1 is not accessed and keeps its contents. The same holds for plane p<3 whose bit p of `multi_page` is 1.
- R6: The written byte is (old & mask) | (new & ~mask), so a mask bit of 1 preserves the old pixel.
- R7: Operation code 0 (fill) gives new = all ones if the plane's colour bit is 1, else all zeros. Code 1 (clear) gives new = all zeros.
- R8: Code 2 (or) gives all ones if the colour bit is 1, else old. Code 3 (and) gives old if the colour bit is 1, else all zeros.
- R9: Code 4 (xor) gives ~old if the colour bit is 1, else old. Code 5 (invert) always gives ~old.
- R10: Code 6 (tile) gives the plane's own tile byte as new value.
- R11: Code 7 (compare) performs no memory access in this block.
- R12: With operation bit 6 set, the written byte takes the masked result where `cmp_status` is 1 and old data where it is 0. If bit 5 is also set, that sense is inverted.
- R13: If no plane is enabled, a start pulse causes no memory access and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Readback of selected register |
| op_start | input | 1 | Launch a job (ignored while busy) |
| op_addr | input | ADDR_W | Byte address of the job |
| plane_count | input | 3 | Number of active planes, capped at 4 |
| multi_page | input | MP_W | Planes excluded from access |
| cmp_status | input | DATA_W | Compare-status byte for write gating |
| busy | output | 1 | High while a job runs |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_plane | output | 2 | Plane index of the access |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
The assertions rely on three assumptions about the environment. Registers, `plane_count`, `multi_page` and `cmp_status` must stay still while `busy` is high. `mem_rdata` must carry the addressed plane's byte in the cycle after a read request. `op_start` must only be raised while the block is idle. The bench meets these conditions by loading all registers and side inputs before each pulse and holding them until `busy` falls. Its memory model returns data with exactly one cycle of latency, and it pulses start only from idle.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
   typedef enum logic [2:0] {
      OP_FILL   = 3'd0,
      OP_CLEAR  = 3'd1,
      OP_OR     = 3'd2,
      OP_AND    = 3'd3,
      OP_XOR    = 3'd4,
      OP_INVERT = 3'd5,
      OP_TILE   = 3'd6,
      OP_CMP    = 3'd7
   } rlu_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_READ  = 2'd1,
      SQ_WRITE = 2'd2
   } seq_state_e;

   localparam int CMD_RUN_BIT      = 7;
   localparam int CMD_GATE_BIT     = 6;
   localparam int CMD_GATE_INV_BIT = 5;
   localparam int PLANE_W          = 2;
   localparam int MAX_PLANES       = 4;

   localparam logic [2:0] RA_CMD   = 3'd0;
   localparam logic [2:0] RA_COLOR = 3'd1;
   localparam logic [2:0] RA_MASK  = 3'd2;
   localparam logic [2:0] RA_SKIP  = 3'd3;
   localparam logic [2:0] RA_TILE0 = 3'd4;
endpackage

// File: rtl/rlu_regs.sv
module rlu_regs
   import rlu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_PLANES = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [2:0]                       addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   output logic [7:0]                       cmd_q,
   output logic [7:0]                       color_q,
   output logic [DATA_W-1:0]                mask_q,
   output logic [7:0]                       skip_q,
   output logic [NUM_PLANES-1:0][DATA_W-1:0] tile_q
);
   localparam int PAD_W = DATA_W - 8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         color_q <= '0;
         mask_q  <= '0;
         skip_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            RA_CMD:   cmd_q   <= wdata[7:0];
            RA_COLOR: color_q <= wdata[7:0];
            RA_MASK:  mask_q  <= wdata;
            RA_SKIP:  skip_q  <= wdata[7:0];
            default:  ;
         endcase
      end
   end

   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_tile
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tile_q[p] <= '0;
         else if (wr_en && addr == RA_TILE0 + 3'(p))
            tile_q[p] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_CMD:   rdata = {{PAD_W{1'b0}}, cmd_q};
         RA_COLOR: rdata = {{PAD_W{1'b0}}, color_q};
         RA_MASK:  rdata = mask_q;
         RA_SKIP:  rdata = {{PAD_W{1'b0}}, skip_q};
         default: begin
            for (int p = 0; p < NUM_PLANES; p++)
               if (addr == RA_TILE0 + 3'(p)) rdata = tile_q[p];
         end
      endcase
   end
endmodule

// File: rtl/rlu_pixel_alu.sv
module rlu_pixel_alu
   import rlu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  rlu_op_e            op,
   input  logic               color_bit,
   input  logic [DATA_W-1:0]  old_data,
   input  logic [DATA_W-1:0]  tile_data,
   input  logic [DATA_W-1:0]  mask,
   input  logic               gate_en,
   input  logic               gate_inv,
   input  logic [DATA_W-1:0]  status,
   output logic [DATA_W-1:0]  result
);
   localparam logic [DATA_W-1:0] ONES = '1;

   logic [DATA_W-1:0] new_data;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] sel;

   always_comb begin
      unique case (op)
         OP_FILL:   new_data = color_bit ? ONES : '0;
         OP_CLEAR:  new_data = '0;
         OP_OR:     new_data = color_bit ? ONES : old_data;
         OP_AND:    new_data = color_bit ? old_data : '0;
         OP_XOR:    new_data = color_bit ? ~old_data : old_data;
         OP_INVERT: new_data = ~old_data;
         OP_TILE:   new_data = tile_data;
         default:   new_data = old_data;
      endcase
   end

   assign merged = (old_data & mask) | (new_data & ~mask);
   assign sel    = gate_inv ? ~status : status;
   assign result = gate_en ? ((old_data & ~sel) | (merged & sel)) : merged;
endmodule

// File: rtl/rlu_plane_seq.sv
module rlu_plane_seq
   import rlu_pkg::*;
#(
   parameter int NUM_PLANES = 4,
   parameter int ADDR_W     = 14
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     addr_in,
   input  logic                  run_en,
   input  logic [NUM_PLANES-1:0] plane_en,
   output logic                  busy,
   output logic                  acc_req,
   output logic                  acc_we,
   output logic [PLANE_W-1:0]    acc_plane,
   output logic [ADDR_W-1:0]     acc_addr
);
   seq_state_e            state_q;
   logic [NUM_PLANES-1:0] pend_q;
   logic [NUM_PLANES-1:0] pend_rem;
   logic [PLANE_W-1:0]    cur_q;
   logic [ADDR_W-1:0]     addr_q;
   logic                  launch;

   function automatic logic [PLANE_W-1:0] lowest(input logic [NUM_PLANES-1:0] v);
      logic [PLANE_W-1:0] idx;
      idx = '0;
      for (int i = NUM_PLANES - 1; i >= 0; i--)
         if (v[i]) idx = PLANE_W'(i);
      return idx;
   endfunction

   assign launch = (state_q == SQ_IDLE) && start && run_en && (|plane_en);

   always_comb begin
      pend_rem = pend_q;
      for (int p = 0; p < NUM_PLANES; p++)
         if (cur_q == PLANE_W'(p)) pend_rem[p] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         pend_q  <= '0;
         cur_q   <= '0;
         addr_q  <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (launch) begin
               pend_q  <= plane_en;
               cur_q   <= lowest(plane_en);
               addr_q  <= addr_in;
               state_q <= SQ_READ;
            end
            SQ_READ: state_q <= SQ_WRITE;
            SQ_WRITE: begin
               pend_q <= pend_rem;
               if (|pend_rem) begin
                  cur_q   <= lowest(pend_rem);
                  state_q <= SQ_READ;
               end else begin
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SQ_IDLE);
   assign acc_req   = busy;
   assign acc_we    = (state_q == SQ_WRITE);
   assign acc_plane = cur_q;
   assign acc_addr  = addr_q;

   // R3: each read is followed by a write to the same plane and address
   a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !acc_we) |=> (acc_req && acc_we && acc_plane == $past(acc_plane)
                                && acc_addr == $past(acc_addr)));

   // R3: planes are visited in strictly ascending order
   a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_we) |=> (!acc_req || acc_plane > $past(acc_plane)));

   // R2: a start pulse without the run bit leaves the sequencer idle
   a_r2_no_run_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !run_en) |=> !busy);

   // R13: a start pulse with no enabled plane leaves the sequencer idle
   a_r13_no_plane_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && plane_en == '0) |=> !busy);
endmodule

// File: rtl/raster_logic_unit.sv
module raster_logic_unit
   import rlu_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int DATA_W     = 8,
   parameter int NUM_PLANES = 4,
   parameter int MP_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              op_start,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [2:0]        plane_count,
   input  logic [MP_W-1:0]   multi_page,
   input  logic [DATA_W-1:0] cmp_status,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [1:0]        mem_plane,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (NUM_PLANES < 1 || NUM_PLANES > MAX_PLANES) begin : g_bad_planes
      $error("raster_logic_unit: NUM_PLANES must be 1..4");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("raster_logic_unit: DATA_W must be at least 8");
   end
   if (MP_W > NUM_PLANES) begin : g_bad_mp
      $error("raster_logic_unit: MP_W must not exceed NUM_PLANES");
   end

   logic [7:0]                       cmd_q;
   logic [7:0]                       color_q;
   logic [DATA_W-1:0]                mask_q;
   logic [7:0]                       skip_q;
   logic [NUM_PLANES-1:0][DATA_W-1:0] tile_q;
   logic [2:0]                       eff_cnt;
   logic [NUM_PLANES-1:0]            plane_en;
   logic                             run_en;
   logic [DATA_W-1:0]                tile_sel;
   rlu_op_e                          op;

   rlu_regs #(.DATA_W(DATA_W), .NUM_PLANES(NUM_PLANES)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .cmd_q   (cmd_q),
      .color_q (color_q),
      .mask_q  (mask_q),
      .skip_q  (skip_q),
      .tile_q  (tile_q)
   );

   assign op      = rlu_op_e'(cmd_q[2:0]);
   assign run_en  = cmd_q[CMD_RUN_BIT] && (op != OP_CMP);
   assign eff_cnt = (plane_count > 3'(NUM_PLANES)) ? 3'(NUM_PLANES) : plane_count;

   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_en
      if (p < MP_W) begin : g_mp
         assign plane_en[p] = (3'(p) < eff_cnt) && !skip_q[p] && !multi_page[p];
      end else begin : g_nomp
         assign plane_en[p] = (3'(p) < eff_cnt) && !skip_q[p];
      end
   end

   rlu_plane_seq #(.NUM_PLANES(NUM_PLANES), .ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (op_start),
      .addr_in   (op_addr),
      .run_en    (run_en),
      .plane_en  (plane_en),
      .busy      (busy),
      .acc_req   (mem_req),
      .acc_we    (mem_we),
      .acc_plane (mem_plane),
      .acc_addr  (mem_addr)
   );

   always_comb begin
      tile_sel = '0;
      for (int p = 0; p < NUM_PLANES; p++)
         if (mem_plane == 2'(p)) tile_sel = tile_q[p];
   end

   rlu_pixel_alu #(.DATA_W(DATA_W)) u_alu (
      .op        (op),
      .color_bit (color_q[mem_plane]),
      .old_data  (mem_rdata),
      .tile_data (tile_sel),
      .mask      (mask_q),
      .gate_en   (cmd_q[CMD_GATE_BIT]),
      .gate_inv  (cmd_q[CMD_GATE_INV_BIT]),
      .status    (cmp_status),
      .result    (mem_wdata)
   );

   // R6: without gating, masked pixels are written back unchanged
   a_r6_mask_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !cmd_q[CMD_GATE_BIT]) |-> (((mem_wdata ^ mem_rdata) & mask_q) == '0));

   // R12: with gating, pixels outside the selected status sense keep old data
   a_r12_gate_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && cmd_q[CMD_GATE_BIT]) |->
      (((mem_wdata ^ mem_rdata) & (cmd_q[CMD_GATE_INV_BIT] ? cmp_status : ~cmp_status)) == '0));

   // R5: a skipped plane is never accessed
   a_r5_skip_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !skip_q[mem_plane]);

   // R4: accesses stay below the effective plane count
   a_r4_within_count: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (3'(mem_plane) < eff_cnt));

   // R11: the compare code starts no job
   a_r11_compare_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && op_start && op == OP_CMP) |=> !busy);
endmodule

// File: tb/raster_logic_unit_test.sv
module raster_logic_unit_test;
   localparam int ADDR_W = 14;
   localparam int DATA_W = 8;
   localparam logic [7:0] TILE [4] = '{8'h3C, 8'hA5, 8'h0F, 8'hF0};

   typedef struct packed {
      logic [7:0] cmd;
      logic [7:0] col;
      logic [7:0] mask;
      logic [7:0] skip;
      logic [7:0] st;
      logic [7:0] old;
      logic [2:0] mp;
      logic [2:0] cnt;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{8'h80, 8'h05, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd7},  // R7 fill
      '{8'h80, 8'h0A, 8'hF0, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd6},  // R6 mask
      '{8'h81, 8'h0F, 8'h0F, 8'h00, 8'h00, 8'hC3, 3'd0, 3'd4, 8'd7},  // R7 clear
      '{8'h82, 8'h03, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd8},  // R8 or
      '{8'h83, 8'h06, 8'h81, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd8},  // R8 and
      '{8'h84, 8'h09, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd9},  // R9 xor
      '{8'h85, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd9},  // R9 invert
      '{8'h86, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd10}, // R10 tile
      '{8'h86, 8'h00, 8'hAA, 8'h05, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd5},  // R5 skip bits
      '{8'h84, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd2, 3'd4, 8'd5},  // R5 multi-page
      '{8'h80, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd2, 8'd4},  // R4 two planes
      '{8'h80, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd7, 8'd4},  // R4 capped
      '{8'hC0, 8'h0F, 8'h00, 8'h00, 8'h0F, 8'h5A, 3'd0, 3'd4, 8'd12}, // R12 gate
      '{8'hE0, 8'h0F, 8'h00, 8'h00, 8'h0F, 8'h5A, 3'd0, 3'd4, 8'd12}, // R12 inverted
      '{8'h00, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd2},  // R2 no run bit
      '{8'h87, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd11}, // R11 compare
      '{8'h80, 8'h0F, 8'h00, 8'h0F, 8'h00, 8'h5A, 3'd0, 3'd4, 8'd13}, // R13 all skipped
      '{8'hC6, 8'h00, 8'h11, 8'h00, 8'h5A, 8'h3C, 3'd0, 3'd4, 8'd12}, // R12 tile gated
      '{8'h80, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h5A, 3'd0, 3'd0, 8'd13}  // R13 zero count
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              op_start = 1'b0;
   logic [ADDR_W-1:0] op_addr = '0;
   logic [2:0]        plane_count = 3'd4;
   logic [2:0]        multi_page = '0;
   logic [DATA_W-1:0] cmp_status = '0;
   logic              busy, mem_req, mem_we;
   logic [1:0]        mem_plane;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata = '0;

   logic [7:0] vmem [4][16];
   logic [1:0] log_plane [16];
   logic       log_we    [16];
   logic [ADDR_W-1:0] log_addr [16];
   int n_log = 0;
   int n_busy = 0;
   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   raster_logic_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_start(op_start),
      .op_addr(op_addr), .plane_count(plane_count), .multi_page(multi_page),
      .cmp_status(cmp_status), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_plane(mem_plane), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) vmem[mem_plane][mem_addr[3:0]] <= mem_wdata;
         else        mem_rdata <= vmem[mem_plane][mem_addr[3:0]];
         if (n_log < 16) begin
            log_plane[n_log] <= mem_plane;
            log_we[n_log]    <= mem_we;
            log_addr[n_log]  <= mem_addr;
         end
         n_log <= n_log + 1;
      end
   end

   always @(negedge clk) if (busy) n_busy <= n_busy + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic bit plane_on(input vec_t v, input int p);
      int lim;
      lim = (v.cnt > 3'd4) ? 4 : int'(v.cnt);
      return v.cmd[7] && (v.cmd[2:0] != 3'd7) && (p < lim) && !v.skip[p]
             && !(p < 3 && v.mp[p]);
   endfunction

   function automatic logic [7:0] model(input vec_t v, input int p, input logic [7:0] old);
      logic [7:0] nv, r, s;
      case (v.cmd[2:0])
         3'd0: nv = v.col[p] ? 8'hFF : 8'h00;
         3'd1: nv = 8'h00;
         3'd2: nv = v.col[p] ? 8'hFF : old;
         3'd3: nv = v.col[p] ? old : 8'h00;
         3'd4: nv = v.col[p] ? ~old : old;
         3'd5: nv = ~old;
         3'd6: nv = TILE[p];
         default: nv = old;
      endcase
      r = (old & v.mask) | (nv & ~v.mask);
      s = v.cmd[5] ? ~v.st : v.st;
      if (v.cmd[6]) r = (old & ~s) | (r & s);
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(busy == 1'b0, "R1 busy", busy, 0);
      check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
      for (int a = 0; a < 8; a++) begin
         reg_addr = 3'(a);
         #1;
         check(reg_rdata == 8'h00, "R1 register", reg_rdata, 0);
      end
      for (int p = 0; p < 4; p++) wr_reg(3'(4 + p), TILE[p]);
      reg_addr = 3'd5;
      #1;
      check(reg_rdata == TILE[1], "R1 tile readback", reg_rdata, TILE[1]);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic [7:0] oldv [4];
         int nexp;
         int k;
         v = VECS[i];
         wr_reg(3'd0, v.cmd);
         wr_reg(3'd1, v.col);
         wr_reg(3'd2, v.mask);
         wr_reg(3'd3, v.skip);
         @(negedge clk);
         plane_count = v.cnt;
         multi_page  = v.mp;
         cmp_status  = v.st;
         op_addr     = 14'h2A40 + 14'(i);
         nexp = 0;
         for (int p = 0; p < 4; p++) begin
            oldv[p] = v.old + 8'(p * 8'h24);
            vmem[p][op_addr[3:0]] = oldv[p];
            if (plane_on(v, p)) nexp++;
         end
         n_log = 0;
         n_busy = 0;
         op_start = 1'b1;
         @(negedge clk);
         op_start = 1'b0;
         while (busy) @(negedge clk);
         @(negedge clk);
         // R3: busy duration and access count
         check(n_busy == 2 * nexp, $sformatf("R%0d/R3 busy cycles v%0d", v.req, i), n_busy, 2 * nexp);
         check(n_log == 2 * nexp, $sformatf("R%0d/R3 access count v%0d", v.req, i), n_log, 2 * nexp);
         k = 0;
         for (int p = 0; p < 4; p++) begin
            if (plane_on(v, p) && k + 1 < 16) begin
               check(log_plane[k] == 2'(p) && !log_we[k] && log_plane[k+1] == 2'(p)
                     && log_we[k+1] && log_addr[k] == op_addr && log_addr[k+1] == op_addr,
                     $sformatf("R3 order v%0d", i), int'(log_plane[k]), p);
               k += 2;
            end
            check(vmem[p][op_addr[3:0]] == (plane_on(v, p) ? model(v, p, oldv[p]) : oldv[p]),
                  $sformatf("R%0d data v%0d plane %0d", v.req, i, p),
                  vmem[p][op_addr[3:0]], plane_on(v, p) ? model(v, p, oldv[p]) : oldv[p]);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule